// File: doc/BRIEF.md
# PTP Clock Pin: Periodic Output and Edge Timestamp Capture

This block owns one timing pin and relates it to the running PTP time. With the mode bit set, it drives the pin with a square wave that has a 50 % duty cycle. The first edge is placed at a programmed 64-bit start time. Each later edge follows the previous one by a programmed 32-bit tick count, which is half of the output period. Single-cycle start and stop pulses control the wave. With the mode bit clear, the block treats the pin as an input and stamps the PTP time of every transition into one capture register. It does not distinguish rising from falling transitions. It has no queue and no fresh-data flag.

A host writes the start time, the half period and the mode, and then pulses start. A start pulse is taken only when the programmed start time still lies ahead of the PTP time that is sampled with the pulse. This lets software pick a phase-aligned future instant without racing the clock. For external events, the host polls the capture register and compares it against the last value it read. Each new transition overwrites that register.

Top module: `ptp_pin_unit`

## Requirements
- R1: While reset is asserted and after it is released, `pin_out` is low and `capture_ts` is zero.
- R2: A start pulse whose `start_time` is equal to or less than the sampled `ptp_time` has no effect: the pin stays low and no edge is ever produced from it.
- R3: After an accepted start, the pin stays low until the first clock edge at which the sampled `ptp_time` is at or past `start_time`. That edge drives it high.
- R4: After the first edge, the pin toggles each time `ptp_time` reaches the previous edge time plus `half_period`. The pin level therefore equals the parity of the number of edge instants `start_time + n*half_period` (n ≥ 0) that have been sampled so far.
- R5: A stop pulse drives the pin low on the next cycle. The pin stays low until another start is accepted. When stop and start arrive in the same cycle, stop wins.
- R6: An accepted start re-arms the wave from a clean low level. The new run's edges follow the new start time.
- R7: With `out_mode` = 1 the pin is driven (`pin_oe` = 1) with the wave. With `out_mode` = 0, `pin_oe` and `pin_out` are both 0.
- R8: With `out_mode` = 0, every rising or falling transition of `pin_in` loads `capture_ts`. The value loaded is the `ptp_time` sampled at the third rising clock edge after the transition: two synchroniser flops, then edge detection.
- R9: A later transition overwrites the earlier capture. Only the latest value is held.
- R10: With `out_mode` = 1, transitions on `pin_in` leave `capture_ts` unchanged. Switching the mode back does not produce a spurious capture.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, PTP time domain |
| rst_n | input | 1 | Synchronous active-low reset |
| ptp_time | input | 64 | Current PTP time in ticks |
| out_mode | input | 1 | 1: periodic output, 0: capture input |
| start_time | input | 64 | Time of the first output edge |
| half_period | input | 32 | Ticks between consecutive output edges |
| start_cmd | input | 1 | One-cycle start pulse |
| stop_cmd | input | 1 | One-cycle stop pulse |
| pin_in | input | 1 | Asynchronous level seen on the pin |
| pin_out | output | 1 | Pin drive value |
| pin_oe | output | 1 | Pin drive enable |
| capture_ts | output | 64 | Last captured PTP time |

## Verification
The bench sweeps half periods from 1 to 6 ticks and several start offsets. At every cycle it compares the pin against the parity of the edge instants that have already passed. An off-by-one compare (`>` instead of `>=`) or a wrong edge step would shift every transition and fail here. Start pulses whose time equals the present time, or lies in the past, must be ignored; a design that arms on them starts toggling. Stop together with start must leave the pin low. Captures are checked one cycle early and then on the exact cycle, with both polarities and back-to-back overwrites, so a missing synchroniser stage or a single-edge detector shows up. A pin toggle in output mode, followed by a return to input mode, catches a design that leaves its edge detector stale.

// File: rtl/ptp_pin_pkg.sv
// Shared types for the PTP clock pin unit.
// Assumes nothing beyond a single clock domain for all users.
package ptp_pin_pkg;
    typedef enum logic [1:0] {
        WG_IDLE  = 2'd0,
        WG_ARMED = 2'd1,
        WG_RUN   = 2'd2
    } wg_state_t;
endpackage

// File: rtl/ptp_pin_sync.sv
// Multi-flop synchroniser for the asynchronous pin level.
// Assumes STAGES >= 2; the output lags the input by STAGES clocks.
module ptp_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    // Shift the pin level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/ptp_pin_capture.sv
// Stamps the PTP time on every transition of the synchronised pin.
// Assumes pin_s is already synchronous. The edge detector tracks the pin
// even while capture is disabled, so enabling never sees a stale edge.
module ptp_pin_capture #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              pin_s,
    input  logic [TIME_W-1:0] ptp_time,
    output logic [TIME_W-1:0] stamp
);
    logic prev_q;
    logic any_edge;

    assign any_edge = pin_s ^ prev_q;

    // Remember the last pin level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_s;
    end

    // Overwrite the capture on each edge while enabled.
    always_ff @(posedge clk) begin
        if (!rst_n)                 stamp <= '0;
        else if (enable && any_edge) stamp <= ptp_time;
    end

    assert_hold_in_output_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> $stable(stamp));

    assert_capture_on_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (pin_s != prev_q)) |=> (stamp == $past(ptp_time)));
endmodule

// File: rtl/ptp_pin_wavegen.sv
// Square-wave generator scheduled against absolute PTP time.
// Holds the absolute time of the next edge and toggles when that time is
// reached or passed. Assumes TIME_W > DUR_W and a nonzero half period.
module ptp_pin_wavegen
    import ptp_pin_pkg::*;
#(
    parameter int TIME_W = 64,
    parameter int DUR_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic [TIME_W-1:0] start_time,
    input  logic [DUR_W-1:0]  half_period,
    input  logic [TIME_W-1:0] ptp_time,
    output logic              wave
);
    localparam int PAD_W = TIME_W - DUR_W;

    wg_state_t         state;
    logic              wave_q;
    logic [TIME_W-1:0] next_edge;
    logic [TIME_W-1:0] step;
    logic              start_ok;
    logic              due;

    assign step     = {{PAD_W{1'b0}}, half_period};
    assign start_ok = start_time > ptp_time;
    assign due      = ptp_time >= next_edge;

    // Sequence arm, toggle and stop; stop has highest priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= WG_IDLE;
            wave_q    <= 1'b0;
            next_edge <= '0;
        end else if (stop_cmd) begin
            state  <= WG_IDLE;
            wave_q <= 1'b0;
        end else if (start_cmd && start_ok) begin
            state     <= WG_ARMED;
            wave_q    <= 1'b0;
            next_edge <= start_time;
        end else if ((state != WG_IDLE) && due) begin
            state     <= WG_RUN;
            wave_q    <= ~wave_q;
            next_edge <= next_edge + step;
        end
    end

    assign wave = wave_q;

    assert_stop_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        stop_cmd |=> (state == WG_IDLE && !wave_q));

    assert_idle_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WG_IDLE) |-> !wave_q);

    assert_armed_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WG_ARMED) |-> !wave_q);

    assert_late_start_ignored_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WG_IDLE && start_cmd && !stop_cmd && start_time <= ptp_time)
        |=> (state == WG_IDLE && !wave_q));

    assert_edge_toggles_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WG_IDLE && due && !start_cmd && !stop_cmd)
        |=> (wave_q != $past(wave_q)));
endmodule

// File: rtl/ptp_pin_unit.sv
// PTP clock pin unit: periodic output or edge timestamp capture on one pin.
// out_mode selects the function; the generator and the edge tracker run in
// both modes, only the drive and the capture enable depend on the mode.
module ptp_pin_unit #(
    parameter int TIME_W      = 64,
    parameter int DUR_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] ptp_time,
    input  logic              out_mode,
    input  logic [TIME_W-1:0] start_time,
    input  logic [DUR_W-1:0]  half_period,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic              pin_in,
    output logic              pin_out,
    output logic              pin_oe,
    output logic [TIME_W-1:0] capture_ts
);
    logic wave;
    logic pin_s;

    ptp_pin_wavegen #(.TIME_W(TIME_W), .DUR_W(DUR_W)) u_wavegen (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_cmd  (start_cmd),
        .stop_cmd   (stop_cmd),
        .start_time (start_time),
        .half_period(half_period),
        .ptp_time   (ptp_time),
        .wave       (wave)
    );

    ptp_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    (pin_in),
        .q    (pin_s)
    );

    ptp_pin_capture #(.TIME_W(TIME_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (!out_mode),
        .pin_s   (pin_s),
        .ptp_time(ptp_time),
        .stamp   (capture_ts)
    );

    // Drive the pin only in output mode.
    assign pin_oe  = out_mode;
    assign pin_out = out_mode & wave;
endmodule

// File: tb/ptp_pin_unit_bench.sv
module ptp_pin_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] ptp_time = 64'd1000;
    logic        out_mode = 1'b1;
    logic [63:0] start_time = '0;
    logic [31:0] half_period = 32'd1;
    logic        start_cmd = 1'b0;
    logic        stop_cmd = 1'b0;
    logic        pin_in = 1'b0;
    logic        pin_out;
    logic        pin_oe;
    logic [63:0] capture_ts;

    int n_vec = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    // Free-running PTP time, one tick per clock.
    always @(posedge clk) ptp_time <= ptp_time + 64'd1;

    ptp_pin_unit u_ptp_pin_unit (
        .clk(clk), .rst_n(rst_n), .ptp_time(ptp_time), .out_mode(out_mode),
        .start_time(start_time), .half_period(half_period),
        .start_cmd(start_cmd), .stop_cmd(stop_cmd), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .capture_ts(capture_ts)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_stop();
        stop_cmd = 1'b1;
        @(negedge clk);
        stop_cmd = 1'b0;
    endtask

    // Expected level: parity of edge instants S+n*H already sampled (t-1).
    function automatic logic exp_level(logic [63:0] t, logic [63:0] s, logic [63:0] h);
        logic [63:0] cnt;
        if (t - 64'd1 >= s) cnt = (t - 64'd1 - s) / h + 64'd1;
        else                cnt = 64'd0;
        return cnt[0];
    endfunction

    task automatic run_wave(input int h, input int off, input string req);
        logic [63:0] s;
        half_period = h;
        s = ptp_time + off;
        start_time = s;
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        for (int c = 0; c < off + 6 * h + 4; c++) begin
            logic e;
            e = exp_level(ptp_time, s, h);
            if (ptp_time - 64'd1 < s + h) chk(pin_out == e, "R3 first edge", pin_out, e);
            else                          chk(pin_out == e, req, pin_out, e);
            @(negedge clk);
        end
    endtask

    initial begin
        #(200000 * 10);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [63:0] t0;
        logic [63:0] held;
        // R1 reset state
        repeat (3) @(negedge clk);
        chk(pin_out == 1'b0, "R1 pin in reset", pin_out, 0);
        chk(capture_ts == 64'd0, "R1 capture in reset", capture_ts, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(pin_out == 1'b0, "R1 pin after reset", pin_out, 0);
        chk(capture_ts == 64'd0, "R1 capture after reset", capture_ts, 0);
        chk(pin_oe == 1'b1, "R7 drive enable in output mode", pin_oe, 1);

        // R3/R4 sweep over half periods and start offsets, stopping between runs
        for (int h = 1; h <= 6; h++) begin
            for (int k = 0; k < 3; k++) begin
                int off;
                off = (k == 0) ? 1 : ((k == 1) ? 3 : 8);
                run_wave(h, off, "R4 wave level");
                do_stop();
                chk(pin_out == 1'b0, "R5 low after stop", pin_out, 0);
                for (int c = 0; c < 2 * h + 3; c++) begin
                    @(negedge clk);
                    chk(pin_out == 1'b0, "R5 held low after stop", pin_out, 0);
                end
            end
        end

        // R2 start time equal to current time, then in the past
        for (int k = 0; k < 2; k++) begin
            half_period = 2;
            start_time = (k == 0) ? ptp_time : ptp_time - 64'd5;
            start_cmd = 1'b1;
            @(negedge clk);
            start_cmd = 1'b0;
            for (int c = 0; c < 12; c++) begin
                chk(pin_out == 1'b0, "R2 late start ignored", pin_out, 0);
                @(negedge clk);
            end
        end

        // R5 stop and start in the same cycle: stop wins
        half_period = 2;
        start_time = ptp_time + 2;
        start_cmd = 1'b1;
        stop_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        stop_cmd = 1'b0;
        for (int c = 0; c < 10; c++) begin
            chk(pin_out == 1'b0, "R5 stop beats start", pin_out, 0);
            @(negedge clk);
        end

        // R6 restart while running re-arms from low
        run_wave(3, 2, "R4 wave level");
        run_wave(2, 5, "R6 restart follows new start");
        do_stop();

        // R7 capture mode: no drive even with a running wave
        start_time = ptp_time + 1;
        half_period = 1;
        start_cmd = 1'b1;
        @(negedge clk);
        start_cmd = 1'b0;
        out_mode = 1'b0;
        for (int c = 0; c < 6; c++) begin
            @(negedge clk);
            chk(pin_out == 1'b0, "R7 no drive in input mode", pin_out, 0);
            chk(pin_oe == 1'b0, "R7 enable low in input mode", pin_oe, 0);
        end
        do_stop();

        // R8 both edge polarities, varying gaps; R9 overwrite
        for (int k = 0; k < 8; k++) begin
            held = capture_ts;
            t0 = ptp_time;
            pin_in = ~pin_in;
            @(negedge clk);
            @(negedge clk);
            chk(capture_ts == held, "R8 not yet captured", capture_ts, held);
            @(negedge clk);
            chk(capture_ts == t0 + 64'd2, pin_in ? "R8 rising capture" : "R8 falling capture",
                capture_ts, t0 + 64'd2);
            repeat (k) @(negedge clk);
        end
        // R9 two edges one cycle apart: second replaces first
        t0 = ptp_time;
        pin_in = ~pin_in;
        @(negedge clk);
        pin_in = ~pin_in;
        repeat (4) @(negedge clk);
        chk(capture_ts == t0 + 64'd3, "R9 latest edge overwrites", capture_ts, t0 + 64'd3);

        // R10 edges in output mode are not captured, nor after switching back
        out_mode = 1'b1;
        held = capture_ts;
        pin_in = ~pin_in;
        repeat (5) @(negedge clk);
        chk(capture_ts == held, "R10 no capture in output mode", capture_ts, held);
        out_mode = 1'b0;
        repeat (5) @(negedge clk);
        chk(capture_ts == held, "R10 no spurious capture on mode return", capture_ts, held);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule